// File: doc/BRIEF.md
# Card Socket Event Interrupt Logic

This block watches the pins of one removable-card socket and turns their activity into latched event flags and two interrupt lines for a host. The socket can hold one of three card kinds: a 16-bit memory card, a 16-bit I/O card or a 32-bit bus-mastering card. The kind is given on an input. Three shared socket pins change meaning with the card kind. Each event has its own detection rule: some events fire on any transition and others only on assertion.

Every socket pin passes through a synchronizer and is then compared with its value one cycle earlier. Qualifying edges set sticky flag bits. A flag stays set until the host clears it by writing a one to it. A mask register gates the flags onto a status-change interrupt. A separate functional interrupt follows the synchronized request pin, and only the I/O and 32-bit card kinds produce it. Control and status pins are plain levels. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `sock_evt_irq`

## Requirements
- R1: After reset, the flags, the masks, `sts_irq` and `func_irq` are all zero.
- R2: With `card_type` = 0 (16-bit memory), any transition on `pin_bvd1`, `pin_bvd2` or `pin_rdy` sets flag bit 0, 1 or 2 respectively. The flag reads back as set after the third rising clock edge that follows the pin change.
- R3: With `card_type` = 1 (16-bit I/O), a rising edge on `pin_bvd1` sets flag bit 0. A falling edge on `pin_bvd1` sets nothing, and `pin_bvd2` and `pin_rdy` never set flag bits 1 or 2.
- R4: With `card_type` = 2 (32-bit card), a rising edge on `pin_bvd1` sets flag bit 0. Any transition on `pin_cd1` sets flag bit 1, and any transition on `pin_cd2` sets flag bit 2.
- R5: For every `card_type`, any transition on `pin_cd1` or `pin_cd2` sets flag bit 4 (insertion/removal).
- R6: A one-cycle `pwr_done` pulse sets flag bit 3 at the next rising edge. This input is already synchronous and is not synchronized.
- R7: Writing with `reg_wr`=1 and `reg_addr`=0 clears each flag bit where `reg_wdata` holds a one and leaves the other bits unchanged. If a set and a clear hit the same bit on the same edge, the set wins.
- R8: Writing with `reg_addr`=1 loads the 5-bit mask, which reads back at `reg_addr`=1. `sts_irq` is high exactly when some flag bit and its mask bit are both one.
- R9: `func_irq` follows `pin_rdy` with three edges of latency when `card_type` is 1 or 2. It has no mask. It is held low when `card_type` is 0 or 3.
- R10: On any edge where `card_type` differs from its value at the previous edge, flag bits 0 to 2 are cleared and bits 3 and 4 are kept.
- R11: With `card_type` = 3 (no card), socket pins never set flag bits 0 to 2. Only bits 3 and 4 can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_type | input | 2 | Card kind: 0 memory, 1 I/O, 2 32-bit, 3 none |
| pin_bvd1 | input | 1 | Battery-detect 1 / status-change pin |
| pin_bvd2 | input | 1 | Battery-detect 2 pin |
| pin_rdy | input | 1 | Ready / interrupt-request pin |
| pin_cd1 | input | 1 | Card-detect pin 1 |
| pin_cd2 | input | 1 | Card-detect pin 2 |
| pwr_done | input | 1 | Synchronous pulse at the end of socket power-up |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects flags, 1 selects masks |
| reg_wdata | input | 5 | Write data (one-to-clear for flags) |
| reg_rdata | output | 5 | Read data for the selected register |
| sts_irq | output | 1 | Status-change interrupt |
| func_irq | output | 1 | Functional interrupt |

## Verification
The hardest situations to reach from the ports are collisions on a single edge: a host clear that lands on the same edge as a new event, and a card-kind change that coincides with pending events. The three-edge synchronizer latency decides where a pin edge turns into a flag. The stimulus therefore toggles a pin, waits exactly two edges and then holds the clear strobe across the third edge. A long random phase changes pins, card kinds and writes together, and a behavioural model checks every cycle.

// File: rtl/sock_evt_pkg.sv
package sock_evt_pkg;
  typedef enum logic [1:0] {
    CT_MEM16 = 2'd0,
    CT_IO16  = 2'd1,
    CT_CB32  = 2'd2,
    CT_NONE  = 2'd3
  } card_kind_e;

  localparam int NUM_PIN = 5;
  localparam int PN_BVD1 = 0;
  localparam int PN_BVD2 = 1;
  localparam int PN_RDY  = 2;
  localparam int PN_CD1  = 3;
  localparam int PN_CD2  = 4;

  localparam int NUM_EVT = 5;
  localparam int EV_STS  = 0;
  localparam int EV_AUX1 = 1;
  localparam int EV_AUX2 = 2;
  localparam int EV_PWR  = 3;
  localparam int EV_INS  = 4;

  localparam logic [NUM_EVT-1:0] KIND_BITS = 5'b00111;
endpackage

// File: rtl/sock_sync.sv
module sock_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[NS-2:0], din};
  end

  assign dout = stg[NS-1];
endmodule

// File: rtl/sock_evt_map.sv
module sock_evt_map
  import sock_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  card_kind_e         kind,
  input  logic [NUM_PIN-1:0] pins_s,
  input  logic               pwr_done,
  output logic [NUM_EVT-1:0] set_vec,
  output logic               func_irq
);
  logic [NUM_PIN-1:0] prev_q;
  logic [NUM_PIN-1:0] chg;
  logic [NUM_PIN-1:0] rise;
  logic               fn_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins_s;
  end

  assign chg  = pins_s ^ prev_q;
  assign rise = pins_s & ~prev_q;

  always_comb begin
    set_vec = '0;
    unique case (kind)
      CT_MEM16: begin
        set_vec[EV_STS]  = chg[PN_BVD1];
        set_vec[EV_AUX1] = chg[PN_BVD2];
        set_vec[EV_AUX2] = chg[PN_RDY];
      end
      CT_IO16: begin
        set_vec[EV_STS]  = rise[PN_BVD1];
      end
      CT_CB32: begin
        set_vec[EV_STS]  = rise[PN_BVD1];
        set_vec[EV_AUX1] = chg[PN_CD1];
        set_vec[EV_AUX2] = chg[PN_CD2];
      end
      default: ;
    endcase
    set_vec[EV_PWR] = pwr_done;
    set_vec[EV_INS] = chg[PN_CD1] | chg[PN_CD2];
  end

  assign fn_ok = (kind == CT_IO16) || (kind == CT_CB32);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) func_irq <= 1'b0;
    else        func_irq <= pins_s[PN_RDY] & fn_ok;
  end
endmodule

// File: rtl/sock_flag_bank.sv
module sock_flag_bank #(
  parameter int                N         = 5,
  parameter logic [N-1:0]      SCRUB     = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         scrub,
  input  logic         reg_wr,
  input  logic         reg_addr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] masks,
  output logic [N-1:0] rdata
);
  localparam logic ADDR_FLAG = 1'b0;
  localparam logic ADDR_MASK = 1'b1;

  logic [N-1:0] clr;
  logic [N-1:0] nxt;

  assign clr = (reg_wr && reg_addr == ADDR_FLAG) ? reg_wdata : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic keep;
    assign keep   = !clr[i] && !(scrub && SCRUB[i]);
    assign nxt[i] = set_vec[i] | (flags[i] & keep);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              masks <= '0;
    else if (reg_wr && reg_addr == ADDR_MASK) masks <= reg_wdata;
  end

  assign rdata = (reg_addr == ADDR_MASK) ? masks : flags;
endmodule

// File: rtl/sock_evt_irq.sv
module sock_evt_irq
  import sock_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         card_type,
  input  logic               pin_bvd1,
  input  logic               pin_bvd2,
  input  logic               pin_rdy,
  input  logic               pin_cd1,
  input  logic               pin_cd2,
  input  logic               pwr_done,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [NUM_EVT-1:0] reg_wdata,
  output logic [NUM_EVT-1:0] reg_rdata,
  output logic               sts_irq,
  output logic               func_irq
);
  card_kind_e         kind;
  card_kind_e         type_q;
  logic               type_chg;
  logic [NUM_PIN-1:0] pins_raw;
  logic [NUM_PIN-1:0] pins_s;
  logic [NUM_EVT-1:0] evt_set;
  logic [NUM_EVT-1:0] flag_q;
  logic [NUM_EVT-1:0] mask_q;

  assign kind = card_kind_e'(card_type);

  assign pins_raw[PN_BVD1] = pin_bvd1;
  assign pins_raw[PN_BVD2] = pin_bvd2;
  assign pins_raw[PN_RDY]  = pin_rdy;
  assign pins_raw[PN_CD1]  = pin_cd1;
  assign pins_raw[PN_CD2]  = pin_cd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_q <= CT_MEM16;
    else        type_q <= kind;
  end

  assign type_chg = (kind != type_q);

  sock_sync #(.W(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_raw),
    .dout  (pins_s)
  );

  sock_evt_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .pins_s   (pins_s),
    .pwr_done (pwr_done),
    .set_vec  (evt_set),
    .func_irq (func_irq)
  );

  sock_flag_bank #(.N(NUM_EVT), .SCRUB(KIND_BITS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (evt_set),
    .scrub     (type_chg),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flag_q),
    .masks     (mask_q),
    .rdata     (reg_rdata)
  );

  assign sts_irq = |(flag_q & mask_q);
endmodule

// File: rtl/sock_evt_irq_chk.sv
module sock_evt_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] card_type,
  input logic [1:0] type_q,
  input logic       reg_wr,
  input logic       reg_addr,
  input logic [4:0] reg_wdata,
  input logic       pwr_done,
  input logic [4:0] set_vec,
  input logic [4:0] flags,
  input logic       sts_irq,
  input logic       func_irq
);
  assert_pwr_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_done |=> flags[3]);

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  assert_no_stray_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags) & ~flags)) |-> ($past(reg_wr) || ($past(card_type) != $past(type_q))));

  assert_mask_zero_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr && reg_wdata == 5'd0) |=> !sts_irq);

  assert_mem_no_func_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (card_type == 2'd0 || card_type == 2'd3) |=> !func_irq);

  assert_kind_scrub_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (card_type != type_q) |=> ((flags[2:0] & ~$past(set_vec[2:0])) == 3'd0));

  assert_none_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (card_type == 2'd3 && type_q == 2'd3) |-> (flags[2:0] == 3'd0));
endmodule

bind sock_evt_irq sock_evt_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .card_type (card_type),
  .type_q    (type_q),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pwr_done  (pwr_done),
  .set_vec   (evt_set),
  .flags     (flag_q),
  .sts_irq   (sts_irq),
  .func_irq  (func_irq)
);

// File: tb/sock_evt_irq_bench.sv
module sock_evt_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] card_type = 2'd0;
  logic       pin_bvd1 = 1'b0, pin_bvd2 = 1'b0, pin_rdy = 1'b0, pin_cd1 = 1'b0, pin_cd2 = 1'b0;
  logic       pwr_done = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_addr = 1'b0;
  logic [4:0] reg_wdata = 5'd0;
  logic [4:0] reg_rdata;
  logic       sts_irq, func_irq;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sock_evt_irq u_sock_evt_irq (
    .clk(clk), .rst_n(rst_n), .card_type(card_type),
    .pin_bvd1(pin_bvd1), .pin_bvd2(pin_bvd2), .pin_rdy(pin_rdy),
    .pin_cd1(pin_cd1), .pin_cd2(pin_cd2), .pwr_done(pwr_done),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sts_irq(sts_irq), .func_irq(func_irq)
  );

  // behavioural reference model
  logic [4:0] hist [$];
  logic [4:0] m_flags, m_mask;
  logic [1:0] m_type;
  logic       m_func;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{5'd0, 5'd0, 5'd0};
      m_flags = 5'd0; m_mask = 5'd0; m_type = 2'd0; m_func = 1'b0;
    end else begin
      logic [4:0] cur, prv, chg, rise, setv, clr;
      cur = hist[1]; prv = hist[2];
      chg = cur ^ prv; rise = cur & ~prv;
      setv = 5'd0;
      if (card_type == 2'd0) setv[2:0] = chg[2:0];
      if (card_type == 2'd1) setv[0] = rise[0];
      if (card_type == 2'd2) setv[2:0] = {chg[4], chg[3], rise[0]};
      setv[3] = pwr_done;
      setv[4] = chg[3] | chg[4];
      clr = (reg_wr && !reg_addr) ? reg_wdata : 5'd0;
      if (card_type != m_type) clr = clr | 5'b00111;
      m_flags = (m_flags & ~clr) | setv;
      if (reg_wr && reg_addr) m_mask = reg_wdata;
      m_func = cur[2] && (card_type == 2'd1 || card_type == 2'd2);
      m_type = card_type;
      hist.push_front({pin_cd2, pin_cd1, pin_rdy, pin_bvd2, pin_bvd1});
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      chk(cur_req, "model rdata", reg_rdata, reg_addr ? m_mask : m_flags);
      chk(cur_req, "model sts_irq", {4'd0, sts_irq}, {4'd0, |(m_flags & m_mask)});
      chk(cur_req, "model func_irq", {4'd0, func_irq}, {4'd0, m_func});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [4:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 5'd0;
  endtask

  task automatic rd(string req, logic a, logic [4:0] exp);
    reg_addr = a;
    #1;
    chk(req, a ? "mask" : "flags", reg_rdata, exp);
  endtask

  task automatic pulse_pwr();
    pwr_done = 1'b1;
    @(negedge clk);
    pwr_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    rd("R1", 1'b0, 5'h00);
    rd("R1", 1'b1, 5'h00);
    chk("R1", "sts_irq", {4'd0, sts_irq}, 5'd0);
    chk("R1", "func_irq", {4'd0, func_irq}, 5'd0);

    cur_req = "R8";
    wr(1'b1, 5'h1F);
    rd("R8", 1'b1, 5'h1F);

    // R2 memory card transitions, three-edge latency
    cur_req = "R2";
    pin_bvd1 = 1'b1;
    tick(2); rd("R2", 1'b0, 5'h00);
    tick(1); rd("R2", 1'b0, 5'h01);
    chk("R2", "sts_irq", {4'd0, sts_irq}, 5'd1);
    pin_bvd1 = 1'b0; pin_bvd2 = 1'b1; pin_rdy = 1'b1;
    tick(3); rd("R2", 1'b0, 5'h07);
    chk("R9", "func_irq mem", {4'd0, func_irq}, 5'd0);
    tick(1); wr(1'b0, 5'h1F); rd("R7", 1'b0, 5'h00);

    // R7 write-one-to-clear and collision
    cur_req = "R7";
    pin_bvd1 = 1'b1; tick(3); rd("R7", 1'b0, 5'h01);
    wr(1'b0, 5'h00); rd("R7", 1'b0, 5'h01);
    wr(1'b0, 5'h1E); rd("R7", 1'b0, 5'h01);
    wr(1'b0, 5'h01); rd("R7", 1'b0, 5'h00);
    pin_bvd1 = 1'b0; tick(2);
    wr(1'b0, 5'h01); rd("R7", 1'b0, 5'h01);
    wr(1'b0, 5'h01); rd("R7", 1'b0, 5'h00);

    // R8 mask gating
    cur_req = "R8";
    pin_bvd2 = 1'b0; tick(3); rd("R8", 1'b0, 5'h02);
    wr(1'b1, 5'h00); chk("R8", "sts_irq mask0", {4'd0, sts_irq}, 5'd0);
    wr(1'b1, 5'h02); chk("R8", "sts_irq match", {4'd0, sts_irq}, 5'd1);
    wr(1'b1, 5'h01); chk("R8", "sts_irq other", {4'd0, sts_irq}, 5'd0);
    wr(1'b1, 5'h1F); rd("R8", 1'b1, 5'h1F);

    // R6 power-done, R5 insertion
    cur_req = "R6";
    pulse_pwr(); rd("R6", 1'b0, 5'h0A);
    cur_req = "R5";
    pin_cd1 = 1'b1; tick(3); rd("R5", 1'b0, 5'h1A);
    tick(1);

    // R10 kind change scrub
    cur_req = "R10";
    card_type = 2'd1; tick(1); rd("R10", 1'b0, 5'h18);
    chk("R9", "func_irq io level", {4'd0, func_irq}, 5'd1);
    wr(1'b0, 5'h1F); rd("R10", 1'b0, 5'h00);

    // R3 I/O card, R9 functional request
    cur_req = "R9";
    pin_rdy = 1'b0;
    tick(2); chk("R9", "func_irq hold", {4'd0, func_irq}, 5'd1);
    tick(1); chk("R9", "func_irq drop", {4'd0, func_irq}, 5'd0);
    cur_req = "R3";
    pin_bvd1 = 1'b1; tick(3); rd("R3", 1'b0, 5'h01);
    pin_bvd1 = 1'b0; tick(3); rd("R3", 1'b0, 5'h01);
    wr(1'b0, 5'h1F);
    pin_bvd2 = 1'b1; tick(4); rd("R3", 1'b0, 5'h00);
    pin_rdy = 1'b1;
    tick(2); chk("R9", "func_irq rise early", {4'd0, func_irq}, 5'd0);
    tick(1); chk("R9", "func_irq rise", {4'd0, func_irq}, 5'd1);
    rd("R3", 1'b0, 5'h00);

    // R4 32-bit card
    cur_req = "R4";
    card_type = 2'd2; tick(1); rd("R4", 1'b0, 5'h00);
    pin_cd2 = 1'b1; tick(3); rd("R4", 1'b0, 5'h14);
    pin_cd1 = 1'b0; tick(3); rd("R4", 1'b0, 5'h16);
    pin_bvd1 = 1'b1; tick(3); rd("R4", 1'b0, 5'h17);
    chk("R9", "func_irq cb", {4'd0, func_irq}, 5'd1);
    wr(1'b0, 5'h1F);
    pin_bvd1 = 1'b0; tick(4); rd("R4", 1'b0, 5'h00);

    // R11 no card
    cur_req = "R11";
    card_type = 2'd3; tick(1);
    chk("R9", "func_irq none", {4'd0, func_irq}, 5'd0);
    pin_bvd1 = 1'b1; pin_bvd2 = 1'b0; pin_rdy = 1'b0;
    tick(4); rd("R11", 1'b0, 5'h00);
    pin_cd2 = 1'b0; tick(3); rd("R5", 1'b0, 5'h10);
    pulse_pwr(); rd("R11", 1'b0, 5'h18);

    // memory card again: ready edge flags, no functional interrupt
    cur_req = "R9";
    card_type = 2'd0; pin_rdy = 1'b1;
    tick(4);
    chk("R9", "func_irq mem high", {4'd0, func_irq}, 5'd0);
    rd("R2", 1'b0, 5'h1C);

    // random mix checked against the model every cycle
    cur_req = "random R7";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6)  pin_bvd1 = ~pin_bvd1;
      if (r >= 6 && r < 10)  pin_bvd2 = ~pin_bvd2;
      if (r >= 10 && r < 15) pin_rdy = ~pin_rdy;
      if (r >= 15 && r < 18) pin_cd1 = ~pin_cd1;
      if (r >= 18 && r < 21) pin_cd2 = ~pin_cd2;
      if (r >= 21 && r < 23) card_type = 2'($urandom_range(0, 3));
      pwr_done = ($urandom_range(0, 29) == 0);
      reg_addr = 1'($urandom_range(0, 1));
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_wdata = 5'($urandom_range(0, 31));
      @(negedge clk);
    end
    reg_wr = 1'b0; pwr_done = 1'b0;
    tick(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule